// File: doc/BRIEF.md
# Masked Interrupt Aggregator with Sticky Status

The aggregator gathers interrupt requests from four peripheral sources into one 32-bit status word and drives a single interrupt line toward the processor. Three of the sources are level-following: an Ethernet controller on bit 8 and two serial controllers on bits 6 and 7. Each of these status bits mirrors the level of its request line. The fourth source is a real-time clock on bit 5. Its bit is sticky. It is set by the request and stays set until software clears it, either by reading the status word or by writing a one to that bit.

A 32-bit enable mask selects which status bits may raise the interrupt line. A separate 32-bit control word is held for software and has no effect on the interrupt path. All three words sit on a small word-wide register bus. A read returns its data one cycle after the request. The interrupt line is registered.

Top module: `intagg_top`

## Requirements
- R1: `irq_out` is a register. After each clock edge it equals 1 exactly when the bitwise AND of status and mask, as they stood before that edge, is nonzero. A change to a source or to the mask therefore reaches `irq_out` two edges after the input changes.
- R2: While `rtc_req` is high at an edge, status bit 5 becomes 1. The bit stays 1 after `rtc_req` falls.
- R3: A read of the status word (offset 0x4) returns the value held before the read edge, and clears bit 5 at that edge.
- R4: A write to the status word clears every sticky bit that has a 1 in the write data and leaves the other bits unchanged. Bits with no source (bits 0-4 and 9-31) always read 0.
- R5: Status bit 8 follows `eth_req`. It is 1 after an edge where `eth_req` was high and 0 after an edge where it was low.
- R6: Status bits 6 and 7 follow `ser0_req` and `ser1_req` in the same way. Writes and reads of the status word do not change these bits.
- R7: The mask is a 32-bit read/write word at offset 0x8.
- R8: The control word is a 32-bit read/write word at offset 0x0. Its value has no effect on `irq_out`.
- R9: A read (`bus_sel` high, `bus_wr` low) gives `bus_rvalid` high with `bus_rdata` valid in the next cycle. An offset outside 0x0, 0x4 and 0x8 reads as 0.
- R10: Synchronous reset `rst` clears status, mask and control to 0 and deasserts `irq_out`.
- R11: When `rtc_req` is high in the same cycle as a status read or a write that clears bit 5, bit 5 ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rtc_req | input | 1 | Real-time clock request (sticky, bit 5) |
| eth_req | input | 1 | Ethernet controller request (level, bit 8) |
| ser0_req | input | 1 | First serial controller request (level, bit 6) |
| ser1_req | input | 1 | Second serial controller request (level, bit 7) |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| irq_out | output | 1 | Combined masked interrupt |

## Verification
Two events can reach the sticky bit in the same cycle: a set from the real-time clock, and a software clear that comes from either a status read or a write-one-to-clear. The bench holds `rtc_req` high in the very cycle it issues the clearing access. It then judges the outcome in two ways: the interrupt line must stay asserted, and the next status read must still return bit 5. A clearing access without the request serves as the control case, and there the bit must drop.

// File: rtl/intagg_pkg.sv
package intagg_pkg;
  localparam int unsigned REG_DW = 32;

  // Byte offsets of the three words
  localparam logic [7:0] OFS_CTRL = 8'h0;
  localparam logic [7:0] OFS_STAT = 8'h4;
  localparam logic [7:0] OFS_MASK = 8'h8;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_MASK = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/intagg_status.sv
module intagg_status #(
  parameter int unsigned DW = 32,
  parameter logic [DW-1:0] LEVEL_MASK = '0,
  parameter logic [DW-1:0] RDCLR_MASK = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] set_vec,
  input  logic [DW-1:0] w1c_vec,
  input  logic          rd_pulse,
  output logic [DW-1:0] stat_q
);
  for (genvar i = 0; i < DW; i++) begin : g_bit
    logic bit_q;
    if (LEVEL_MASK[i]) begin : g_lvl
      // mirrors its request level, software access has no say
      always_ff @(posedge clk) begin
        if (rst) bit_q <= 1'b0;
        else     bit_q <= set_vec[i];
      end
    end else begin : g_stk
      logic clr;
      assign clr = w1c_vec[i] | (rd_pulse & RDCLR_MASK[i]);
      // a set in the same cycle overrides any clear
      always_ff @(posedge clk) begin
        if (rst) bit_q <= 1'b0;
        else     bit_q <= set_vec[i] | (bit_q & ~clr);
      end
    end
    assign stat_q[i] = bit_q;
  end
endmodule

// File: rtl/intagg_regs.sv
module intagg_regs
  import intagg_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] stat_q,
  output logic [DW-1:0] mask_q,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] w1c_vec,
  output logic          rd_stat,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_rvalid
);
  reg_sel_e sel;
  logic     do_wr;
  logic     do_rd;
  logic [DW-1:0] rd_mux;

  always_comb begin
    if (bus_addr == AW'(OFS_CTRL))      sel = SEL_CTRL;
    else if (bus_addr == AW'(OFS_STAT)) sel = SEL_STAT;
    else if (bus_addr == AW'(OFS_MASK)) sel = SEL_MASK;
    else                                sel = SEL_NONE;
  end

  assign do_wr   = bus_sel & bus_wr;
  assign do_rd   = bus_sel & ~bus_wr;
  assign w1c_vec = (do_wr && sel == SEL_STAT) ? bus_wdata : '0;
  assign rd_stat = do_rd && (sel == SEL_STAT);

  always_comb begin
    unique case (sel)
      SEL_CTRL: rd_mux = ctrl_q;
      SEL_STAT: rd_mux = stat_q;
      SEL_MASK: rd_mux = mask_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      ctrl_q <= '0;
    end else if (do_wr) begin
      if (sel == SEL_MASK) mask_q <= bus_wdata;
      if (sel == SEL_CTRL) ctrl_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= do_rd;
      if (do_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/intagg_irq.sv
module intagg_irq #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] stat_q,
  input  logic [DW-1:0] mask_q,
  output logic          irq_q
);
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(stat_q & mask_q);
  end
endmodule

// File: rtl/intagg_top.sv
module intagg_top #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned RTC_POS  = 5,
  parameter int unsigned SER0_POS = 6,
  parameter int unsigned SER1_POS = 7,
  parameter int unsigned ETH_POS  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rtc_req,
  input  logic              eth_req,
  input  logic              ser0_req,
  input  logic              ser1_req,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              irq_out
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);
  localparam logic [DATA_W-1:0] LEVEL_MASK =
    (ONE << ETH_POS) | (ONE << SER0_POS) | (ONE << SER1_POS);
  localparam logic [DATA_W-1:0] RDCLR_MASK = ONE << RTC_POS;

  logic [DATA_W-1:0] set_vec;
  logic [DATA_W-1:0] w1c_vec;
  logic [DATA_W-1:0] stat_q;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] ctrl_q;
  logic              rd_stat;

  always_comb begin
    set_vec           = '0;
    set_vec[RTC_POS]  = rtc_req;
    set_vec[ETH_POS]  = eth_req;
    set_vec[SER0_POS] = ser0_req;
    set_vec[SER1_POS] = ser1_req;
  end

  intagg_status #(
    .DW(DATA_W), .LEVEL_MASK(LEVEL_MASK), .RDCLR_MASK(RDCLR_MASK)
  ) u_status (
    .clk(clk), .rst(rst), .set_vec(set_vec), .w1c_vec(w1c_vec),
    .rd_pulse(rd_stat), .stat_q(stat_q)
  );

  intagg_regs #(.DW(DATA_W), .AW(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .stat_q(stat_q),
    .mask_q(mask_q), .ctrl_q(ctrl_q), .w1c_vec(w1c_vec), .rd_stat(rd_stat),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  intagg_irq #(.DW(DATA_W)) u_irq (
    .clk(clk), .rst(rst), .stat_q(stat_q), .mask_q(mask_q), .irq_q(irq_out)
  );
endmodule

// File: rtl/intagg_chk.sv
module intagg_chk #(
  parameter int unsigned DW       = 32,
  parameter int unsigned AW       = 4,
  parameter int unsigned RTC_POS  = 5,
  parameter int unsigned SER0_POS = 6,
  parameter int unsigned SER1_POS = 7,
  parameter int unsigned ETH_POS  = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          rtc_req,
  input logic          eth_req,
  input logic          ser0_req,
  input logic          ser1_req,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_rvalid,
  input logic          irq_out,
  input logic [DW-1:0] stat_q,
  input logic [DW-1:0] mask_q
);
  localparam logic [DW-1:0] ONE = DW'(1);
  localparam logic [DW-1:0] SRC_MASK = (ONE << RTC_POS) | (ONE << ETH_POS) |
                                       (ONE << SER0_POS) | (ONE << SER1_POS);
  logic stat_rd;
  logic stat_wr;
  assign stat_rd = bus_sel && !bus_wr && (bus_addr == AW'(4));
  assign stat_wr = bus_sel && bus_wr && (bus_addr == AW'(4));

  a_r1_irq_on: assert property (@(posedge clk) disable iff (rst)
    (|(stat_q & mask_q)) |=> irq_out);
  a_r1_irq_off: assert property (@(posedge clk) disable iff (rst)
    !(|(stat_q & mask_q)) |=> !irq_out);
  a_r2_rtc_sets: assert property (@(posedge clk) disable iff (rst)
    rtc_req |=> stat_q[RTC_POS]);
  a_r3_read_clears: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !rtc_req) |=> !stat_q[RTC_POS]);
  a_r4_unsourced_zero: assert property (@(posedge clk) disable iff (rst)
    (stat_q & ~SRC_MASK) == '0);
  a_r5_eth_level: assert property (@(posedge clk) disable iff (rst)
    eth_req |=> stat_q[ETH_POS]);
  a_r5_eth_drop: assert property (@(posedge clk) disable iff (rst)
    !eth_req |=> !stat_q[ETH_POS]);
  a_r6_ser0_level: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> stat_q[SER0_POS] == $past(ser0_req));
  a_r6_ser1_level: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> stat_q[SER1_POS] == $past(ser1_req));
  a_r9_rvalid_on: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr) |=> bus_rvalid);
  a_r9_rvalid_off: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && !bus_wr) |=> !bus_rvalid);
  a_r10_reset: assert property (@(posedge clk)
    rst |=> (!irq_out && stat_q == '0 && mask_q == '0 && !bus_rvalid));
  a_r11_set_beats_w1c: assert property (@(posedge clk) disable iff (rst)
    (rtc_req && stat_wr && bus_wdata[RTC_POS]) |=> stat_q[RTC_POS]);
endmodule

bind intagg_top intagg_chk #(
  .DW(DATA_W), .AW(ADDR_W), .RTC_POS(RTC_POS), .SER0_POS(SER0_POS),
  .SER1_POS(SER1_POS), .ETH_POS(ETH_POS)
) u_chk (
  .clk(clk), .rst(rst), .rtc_req(rtc_req), .eth_req(eth_req),
  .ser0_req(ser0_req), .ser1_req(ser1_req), .bus_sel(bus_sel),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rvalid(bus_rvalid), .irq_out(irq_out), .stat_q(stat_q),
  .mask_q(mask_q)
);

// File: tb/tb_intagg_top.sv
`timescale 1ns/1ps
module tb_intagg_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rtc_req = 1'b0, eth_req = 1'b0, ser0_req = 1'b0, ser1_req = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        irq_out;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #2 clk = ~clk;

  intagg_top dut (
    .clk(clk), .rst(rst), .rtc_req(rtc_req), .eth_req(eth_req),
    .ser0_req(ser0_req), .ser1_req(ser1_req), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irq_out(irq_out)
  );

  // op codes used by the table
  localparam logic [2:0] OP_IDLE = 3'd0, OP_RSTAT = 3'd1, OP_WSTAT = 3'd2,
                         OP_WMASK = 3'd3, OP_WCTRL = 3'd4, OP_RMASK = 3'd5,
                         OP_RCTRL = 3'd6;

  // {src[3:0]={ser1,ser0,eth,rtc}, op, wdata, expected read, expected irq}
  localparam logic [71:0] VEC [24] = '{
    {4'b0000, OP_RSTAT, 32'h0,        32'h0,        1'b0},
    {4'b0010, OP_WMASK, 32'h100,      32'h0,        1'b1},
    {4'b0000, OP_IDLE,  32'h0,        32'h0,        1'b0},
    {4'b0001, OP_IDLE,  32'h0,        32'h0,        1'b0},
    {4'b0000, OP_WMASK, 32'h20,       32'h0,        1'b1},
    {4'b0000, OP_RSTAT, 32'h0,        32'h20,       1'b0},
    {4'b0001, OP_IDLE,  32'h0,        32'h0,        1'b1},
    {4'b0000, OP_WSTAT, 32'h20,       32'h0,        1'b0},
    {4'b0001, OP_WSTAT, 32'h20,       32'h0,        1'b1},
    {4'b0001, OP_RSTAT, 32'h0,        32'h20,       1'b1},
    {4'b0000, OP_RSTAT, 32'h0,        32'h20,       1'b0},
    {4'b1100, OP_WMASK, 32'h80,       32'h0,        1'b1},
    {4'b1100, OP_RSTAT, 32'h0,        32'hC0,       1'b1},
    {4'b1100, OP_WSTAT, 32'hFFFFFFFF, 32'h0,        1'b1},
    {4'b0100, OP_IDLE,  32'h0,        32'h0,        1'b0},
    {4'b0100, OP_RMASK, 32'h0,        32'h80,       1'b0},
    {4'b0100, OP_WCTRL, 32'hDEADBEEF, 32'h0,        1'b0},
    {4'b0100, OP_RCTRL, 32'h0,        32'hDEADBEEF, 1'b0},
    {4'b0100, OP_RSTAT, 32'h0,        32'h40,       1'b0},
    {4'b1111, OP_WMASK, 32'hFFFFFFFF, 32'h0,        1'b1},
    {4'b1111, OP_RSTAT, 32'h0,        32'h1E0,      1'b1},
    {4'b0000, OP_IDLE,  32'h0,        32'h0,        1'b1},
    {4'b0000, OP_RSTAT, 32'h0,        32'h20,       1'b0},
    {4'b0000, OP_RSTAT, 32'h0,        32'h0,        1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string rd_tag(input logic [2:0] op);
    case (op)
      OP_RSTAT: return "R3/R5/R6 status read";
      OP_RMASK: return "R7 mask read";
      OP_RCTRL: return "R8 ctrl read";
      default:  return "R9 read";
    endcase
  endfunction

  task automatic drive_op(input logic [2:0] op, input logic [31:0] wd);
    bus_sel   = (op != OP_IDLE);
    bus_wr    = (op == OP_WSTAT || op == OP_WMASK || op == OP_WCTRL);
    bus_wdata = wd;
    case (op)
      OP_RSTAT, OP_WSTAT: bus_addr = 4'h4;
      OP_RMASK, OP_WMASK: bus_addr = 4'h8;
      default:            bus_addr = 4'h0;
    endcase
  endtask

  task automatic bus_idle();
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic rd_word(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_idle();
    chk("R9 rvalid", {31'b0, bus_rvalid}, 32'h1);
    d = bus_rdata;
  endtask

  task automatic wr_word(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_idle();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    chk("R10 irq after reset", {31'b0, irq_out}, 32'h0);
    chk("R10 rvalid after reset", {31'b0, bus_rvalid}, 32'h0);
    rd_word(4'h0, d); chk("R10 ctrl", d, 32'h0);
    rd_word(4'h8, d); chk("R10 mask", d, 32'h0);

    // table walk
    for (int i = 0; i < 24; i++) begin
      logic [71:0] v;
      v = VEC[i];
      @(negedge clk);
      {ser1_req, ser0_req, eth_req, rtc_req} = v[71:68];
      drive_op(v[67:65], v[64:33]);
      @(negedge clk);
      bus_idle();
      if (v[67:65] == OP_RSTAT || v[67:65] == OP_RMASK || v[67:65] == OP_RCTRL) begin
        chk("R9 rvalid", {31'b0, bus_rvalid}, 32'h1);
        chk(rd_tag(v[67:65]), bus_rdata, v[32:1]);
      end
      @(negedge clk);
      chk("R1/R2/R11 irq", {31'b0, irq_out}, {31'b0, v[0]});
    end

    // R1 latency: mask all ones, sources idle, status 0
    @(negedge clk);
    eth_req = 1'b1;
    @(negedge clk);
    chk("R1 irq not yet", {31'b0, irq_out}, 32'h0);
    @(negedge clk);
    chk("R1 R5 irq rises", {31'b0, irq_out}, 32'h1);
    eth_req = 1'b0;
    @(negedge clk);
    chk("R1 irq still high", {31'b0, irq_out}, 32'h1);
    @(negedge clk);
    chk("R1 R5 irq falls", {31'b0, irq_out}, 32'h0);

    // R9 unmapped offset
    rd_word(4'hC, d); chk("R9 unmapped read", d, 32'h0);

    // R4 write to bits with no source leaves status 0
    wr_word(4'h4, 32'hFFFFFFFF);
    rd_word(4'h4, d); chk("R4 unsourced bits", d, 32'h0);

    // R8 control has no effect on irq
    wr_word(4'h0, 32'hFFFFFFFF);
    @(negedge clk);
    chk("R8 ctrl no irq", {31'b0, irq_out}, 32'h0);

    // R10 mid-run reset
    @(negedge clk); rtc_req = 1'b1;
    @(negedge clk); rtc_req = 1'b0;
    @(negedge clk);
    chk("R2 irq from sticky", {31'b0, irq_out}, 32'h1);
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R10 irq in reset", {31'b0, irq_out}, 32'h0);
    rst = 1'b0;
    rd_word(4'h4, d); chk("R10 status cleared", d, 32'h0);
    rd_word(4'h8, d); chk("R10 mask cleared", d, 32'h0);
    rd_word(4'h0, d); chk("R10 ctrl cleared", d, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule